// File: doc/BRIEF.md
# Synchronous Burst Host Bus Slave

This block is the slave end of a clocked host bus on which address and write data share one 16-bit bus. A one-cycle address-latch pulse loads the start address from that shared bus. A later falling edge of the active-low data strobe opens the data phase. At that edge the slave samples the transfer kind: read or write, single word or burst, memory or register space, and sequential or random addressing. One clock after the strobe edge is taken, the slave pulls its active-low ready output low. From then on one word moves on every clock until the host marks the last word.

Behind the bus the block drives two simple local ports. The memory port reads with one cycle of latency and may run bursts. The register port only ever performs single-word accesses. A write burst either walks forward from the latched address or takes a fresh address from a separate address bus on every word. A read burst always walks forward. A burst aimed at register space is cut to its first word and raises a sticky error flag.

Top module: `sync_burst_slave`

## Requirements
- R1: When `bus_ale` is high at a clock edge, the value on `bus_ad` becomes the start address of the next access.
- R2: The data strobe is acted on only when its falling edge is seen at a clock edge after the one on which `bus_ale` was sampled high. A strobe that falls in the same cycle as the latch pulse, or earlier, starts no transfer: `bus_rdy_n` stays high and nothing is written.
- R3: When the strobe fall is taken at clock edge N, `bus_rdy_n` is high after edge N and low after edge N+1. One word moves on every clock while it is low, and memory writes happen only while it is low.
- R4: A write burst whose `bus_seq` is 1 at the strobe fall writes word k to the start address plus k. `bus_addr` is ignored.
- R5: A write burst whose `bus_seq` is 0 at the strobe fall writes each word to the value on `bus_addr` in that word's cycle.
- R6: A read burst is always sequential, whatever the value of `bus_seq`. Word k on `bus_rdata` is the memory content at the start address plus k.
- R7: In a burst, the ready-low cycle in which `bus_last_n` is 0 carries the final word. `bus_rdy_n` is high on the following cycle.
- R8: An access with `bus_burst` at 0 moves exactly one word, whatever the value of `bus_last_n`.
- R9: A burst with `bus_regsel` at 1 moves only its first word to or from the register port and sets `bus_err`. `bus_err` then stays at 1 until reset.
- R10: The sequential address counter is 16 bits wide and steps from 0xFFFF to 0x0000.
- R11: After reset, `bus_rdy_n` is 1, `bus_err` is 0, both local port enables are 0 and `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ale | input | 1 | Address-latch pulse |
| bus_ad | input | 16 | Shared address / write-data bus |
| bus_addr | input | 16 | Per-word address for random write bursts |
| bus_stb_n | input | 1 | Active-low data strobe |
| bus_seq | input | 1 | 1 = sequential, 0 = random write burst |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_burst | input | 1 | 1 = burst request |
| bus_regsel | input | 1 | 1 = register space, 0 = memory |
| bus_last_n | input | 1 | Active-low final-word mark |
| bus_rdy_n | output | 1 | Active-low ready; low while words move |
| bus_rdata | output | 16 | Read data during ready-low read cycles |
| bus_err | output | 1 | Sticky flag for a refused register burst |
| ram_en | output | 1 | Memory port enable |
| ram_we | output | 1 | Memory port write enable |
| ram_addr | output | 16 | Memory port address |
| ram_wdata | output | 16 | Memory port write data |
| ram_rdata | input | 16 | Memory read data, one cycle after enable |
| reg_en | output | 1 | Register port enable |
| reg_we | output | 1 | Register port write enable |
| reg_addr | output | 5 | Register port address |
| reg_wdata | output | 16 | Register port write data |
| reg_rdata | input | 16 | Register read data, one cycle after enable |

## Verification
The hardest case to reach is a register-space burst while the host keeps pushing words. The slave must drop every word after the first, even though the host still holds the strobe low and supplies data. The bench drives a three-word register write and a register read burst, with the final-word mark placed on the third word. It then checks that ready rose after one word, that the neighbouring register kept its value, and that the error flag stays set through a later normal access. A second awkward case is a strobe that falls in the same cycle as the latch pulse. The bench drives both together, holds the strobe low for several cycles and confirms that ready never falls and the memory is untouched.

// File: rtl/sync_burst_slave.sv
module sync_burst_slave #(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_ale,
  input  logic [DW-1:0] bus_ad,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_stb_n,
  input  logic          bus_seq,
  input  logic          bus_wr,
  input  logic          bus_burst,
  input  logic          bus_regsel,
  input  logic          bus_last_n,
  output logic          bus_rdy_n,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_err,
  output logic          ram_en,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  input  logic [DW-1:0] ram_rdata,
  output logic          reg_en,
  output logic          reg_we,
  output logic [RW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  input  logic [DW-1:0] reg_rdata
);

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_WAIT, S_XFER} st_t;

  st_t           st;
  logic [AW-1:0] cur;
  logic          stb_q, wr_q, burst_q, reg_q, rand_q, err_q;

  logic stb_fall, in_x, in_w, done, rd_issue;

  assign stb_fall = stb_q & ~bus_stb_n;
  assign in_x     = (st == S_XFER);
  assign in_w     = (st == S_WAIT);
  assign done     = ~burst_q | ~bus_last_n;
  assign rd_issue = ~wr_q & (in_w | (in_x & ~done));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cur     <= '0;
      stb_q   <= 1'b1;
      wr_q    <= 1'b0;
      burst_q <= 1'b0;
      reg_q   <= 1'b0;
      rand_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      stb_q <= bus_stb_n;
      case (st)
        S_IDLE, S_ARMED: begin
          if (bus_ale) begin
            cur <= bus_ad[AW-1:0];
            st  <= S_ARMED;
          end else if (st == S_ARMED && stb_fall) begin
            wr_q    <= bus_wr;
            reg_q   <= bus_regsel;
            burst_q <= bus_burst & ~bus_regsel;
            rand_q  <= bus_wr & bus_burst & ~bus_regsel & ~bus_seq;
            if (bus_burst && bus_regsel) err_q <= 1'b1;
            st <= S_WAIT;
          end
        end
        S_WAIT: st <= S_XFER;
        S_XFER: begin
          cur <= cur + AW'(1);
          if (done) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign bus_rdy_n = ~in_x;
  assign bus_err   = err_q;
  assign bus_rdata = (in_x && !wr_q) ? (reg_q ? reg_rdata : ram_rdata) : '0;

  assign ram_en    = ~reg_q & ((wr_q & in_x) | rd_issue);
  assign ram_we    = ~reg_q & wr_q & in_x;
  assign ram_addr  = rand_q ? bus_addr : ((in_w || wr_q) ? cur : cur + AW'(1));
  assign ram_wdata = bus_ad;

  assign reg_en    = reg_q & (wr_q ? in_x : in_w);
  assign reg_we    = reg_q & wr_q & in_x;
  assign reg_addr  = cur[RW-1:0];
  assign reg_wdata = bus_ad;

endmodule

module sync_burst_slave_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_stb_n,
  input logic          bus_last_n,
  input logic          bus_rdy_n,
  input logic          bus_err,
  input logic          ram_en,
  input logic          ram_we,
  input logic [AW-1:0] ram_addr,
  input logic          reg_en
);

  AST_RDY_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_rdy_n) |-> ($past(bus_stb_n, 2) == 1'b0 && $past(bus_stb_n, 3) == 1'b1)); // R3

  AST_WE_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> !bus_rdy_n); // R3

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rdy_n && !bus_last_n) |=> bus_rdy_n); // R7

  AST_SEQ_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && !ram_we && $past(ram_en && !ram_we)) |-> ram_addr == AW'($past(ram_addr) + AW'(1))); // R6

  AST_REG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_en |=> !reg_en); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> bus_err); // R9

endmodule

bind sync_burst_slave sync_burst_slave_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_stb_n(bus_stb_n), .bus_last_n(bus_last_n),
  .bus_rdy_n(bus_rdy_n), .bus_err(bus_err), .ram_en(ram_en), .ram_we(ram_we),
  .ram_addr(ram_addr), .reg_en(reg_en)
);

// File: tb/tb_sync_burst_slave.sv
`timescale 1ns/1ps
module tb_sync_burst_slave;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ale = 1'b0;
  logic [15:0] ad = '0;
  logic [15:0] baddr = '0;
  logic        stb_n = 1'b1, seq = 1'b1, wr = 1'b0, burst = 1'b0, regs = 1'b0, last_n = 1'b1;
  logic        rdy_n, err;
  logic [15:0] rdata;
  logic        ram_en, ram_we, reg_en, reg_we;
  logic [15:0] ram_addr, ram_wdata, reg_wdata;
  logic [15:0] ram_rdata = '0, reg_rdata = '0;
  logic [4:0]  reg_addr;

  logic [15:0] mem [256];
  logic [15:0] regf [32];
  logic [15:0] wbuf [24];
  logic [15:0] abuf [24];
  logic [15:0] rbuf [24];
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sync_burst_slave dut (
    .clk(clk), .rst_n(rst_n), .bus_ale(ale), .bus_ad(ad), .bus_addr(baddr),
    .bus_stb_n(stb_n), .bus_seq(seq), .bus_wr(wr), .bus_burst(burst),
    .bus_regsel(regs), .bus_last_n(last_n), .bus_rdy_n(rdy_n), .bus_rdata(rdata),
    .bus_err(err), .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) mem[ram_addr[7:0]] <= ram_wdata;
      else        ram_rdata <= mem[ram_addr[7:0]];
    end
    if (reg_en) begin
      if (reg_we) regf[reg_addr] <= reg_wdata;
      else        reg_rdata <= regf[reg_addr];
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic xfer(input logic [15:0] a0, input bit w, input bit b, input bit r,
                      input bit s, input int n, output int moved);
    @(negedge clk); ale = 1'b1; ad = a0;
    @(negedge clk); ale = 1'b0; stb_n = 1'b0; wr = w; burst = b; regs = r; seq = s;
    @(negedge clk); chk("R3", "ready high in wait cycle", rdy_n, 1);
    @(negedge clk); chk("R3", "ready low one clock later", rdy_n, 0);
    moved = 0;
    while (rdy_n == 1'b0 && moved < 20) begin
      ad = wbuf[moved]; baddr = abuf[moved]; last_n = (moved == n - 1) ? 1'b0 : 1'b1;
      #1;
      if (!w) rbuf[moved] = rdata;
      moved++;
      @(negedge clk);
    end
    stb_n = 1'b1; last_n = 1'b1; ad = '0;
  endtask

  task automatic t_reset;
    chk("R11", "ready after reset", rdy_n, 1);
    chk("R11", "err after reset", err, 0);
    chk("R11", "ram_en after reset", ram_en, 0);
    chk("R11", "reg_en after reset", reg_en, 0);
    chk("R11", "rdata after reset", rdata, 0);
  endtask

  task automatic t_seq_write;
    int m;
    logic [15:0] keep = mem[8'h80];
    for (int i = 0; i < 4; i++) begin wbuf[i] = 16'hA100 + 16'(i); abuf[i] = 16'h0080; end
    xfer(16'h0010, 1, 1, 0, 1, 4, m);
    chk("R7", "seq write words moved", m, 4);
    for (int i = 0; i < 4; i++) chk("R4", "seq write content", mem[8'h10 + 8'(i)], 16'hA100 + 16'(i));
    chk("R4", "bus_addr ignored on seq write", mem[8'h80], keep);
  endtask

  task automatic t_rand_write;
    int m;
    logic [15:0] keep = mem[8'h50];
    abuf[0] = 16'h0040; abuf[1] = 16'h0007; abuf[2] = 16'h0093; abuf[3] = 16'h0021;
    for (int i = 0; i < 4; i++) wbuf[i] = 16'hB200 + 16'(i);
    xfer(16'h0050, 1, 1, 0, 0, 4, m);
    chk("R5", "random write words moved", m, 4);
    for (int i = 0; i < 4; i++) chk("R5", "random write content", mem[abuf[i][7:0]], 16'hB200 + 16'(i));
    chk("R5", "latched address untouched", mem[8'h50], keep);
  endtask

  task automatic t_seq_read;
    int m;
    xfer(16'h0010, 0, 1, 0, 0, 4, m);
    chk("R6", "read words moved", m, 4);
    for (int i = 0; i < 4; i++) chk("R6", "read is sequential", rbuf[i], 16'hA100 + 16'(i));
  endtask

  task automatic t_single;
    int m;
    logic [15:0] keep = mem[8'h31];
    for (int i = 0; i < 3; i++) wbuf[i] = 16'hC300 + 16'(i);
    xfer(16'h0030, 1, 0, 0, 1, 3, m);
    chk("R8", "single write moves one word", m, 1);
    chk("R8", "single write content", mem[8'h30], 16'hC300);
    chk("R8", "next word not written", mem[8'h31], keep);
    xfer(16'h0040, 0, 0, 0, 1, 1, m);
    chk("R1", "single read from latched address", rbuf[0], 16'hB200);
    chk("R8", "single read moves one word", m, 1);
  endtask

  task automatic t_reg;
    int m;
    logic [15:0] keep = regf[4];
    for (int i = 0; i < 3; i++) wbuf[i] = 16'hD400 + 16'(i);
    xfer(16'h0003, 1, 0, 1, 1, 1, m);
    chk("R9", "err clear after single reg write", err, 0);
    chk("R9", "single reg write content", regf[3], 16'hD400);
    wbuf[0] = 16'hE500; wbuf[1] = 16'hE501; wbuf[2] = 16'hE502;
    xfer(16'h0003, 1, 1, 1, 1, 3, m);
    chk("R9", "reg burst write cut to one word", m, 1);
    chk("R9", "reg burst first word stored", regf[3], 16'hE500);
    chk("R9", "reg burst second word dropped", regf[4], keep);
    chk("R9", "err set by reg burst", err, 1);
    xfer(16'h0003, 0, 1, 1, 1, 3, m);
    chk("R9", "reg burst read cut to one word", m, 1);
    chk("R9", "reg burst read first word", rbuf[0], 16'hE500);
    xfer(16'h0010, 0, 0, 0, 1, 1, m);
    chk("R9", "err sticky after normal access", err, 1);
  endtask

  task automatic t_wrap;
    int m;
    for (int i = 0; i < 4; i++) wbuf[i] = 16'hF600 + 16'(i);
    xfer(16'hFFFE, 1, 1, 0, 1, 4, m);
    chk("R10", "wrap write moved", m, 4);
    chk("R10", "word at FFFE", mem[8'hFE], 16'hF600);
    chk("R10", "word at FFFF", mem[8'hFF], 16'hF601);
    chk("R10", "word at 0000", mem[8'h00], 16'hF602);
    chk("R10", "word at 0001", mem[8'h01], 16'hF603);
    xfer(16'hFFFF, 0, 1, 0, 1, 2, m);
    chk("R10", "wrap read FFFF", rbuf[0], 16'hF601);
    chk("R10", "wrap read 0000", rbuf[1], 16'hF602);
  endtask

  task automatic t_early_strobe;
    logic [15:0] keep = mem[8'h60];
    @(negedge clk); ale = 1'b1; ad = 16'h0060; stb_n = 1'b0; wr = 1'b1; burst = 1'b0; regs = 1'b0;
    @(negedge clk); ale = 1'b0; ad = 16'h5555;
    for (int i = 0; i < 4; i++) begin
      chk("R2", "early strobe gives no ready", rdy_n, 1);
      @(negedge clk);
    end
    stb_n = 1'b1;
    @(negedge clk);
    chk("R2", "early strobe writes nothing", mem[8'h60], keep);
  endtask

  task automatic t_long;
    int m;
    for (int i = 0; i < 9; i++) begin wbuf[i] = 16'h7000 + 16'(i); abuf[i] = '0; end
    xfer(16'h00A0, 1, 1, 0, 1, 9, m);
    chk("R7", "burst ends on last mark", m, 9);
    chk("R7", "ready high after last", rdy_n, 1);
    chk("R7", "last word stored", mem[8'hA8], 16'h7008);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_seq_write();
    t_rand_write();
    t_seq_read();
    t_single();
    t_reg();
    t_wrap();
    t_early_strobe();
    t_long();
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL R7 watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule